// File: doc/BRIEF.md
# Scoreboard Hazard Tracking Unit

This block is the central hazard tracker for a small out-of-order core in which each functional unit holds the one instruction it was given. Instructions arrive in program order on a dispatch port. Each carries an op class, which names its target unit, one destination register and two source registers. The block accepts an instruction only when its unit is free and no active instruction will write the same destination. It then follows the instruction through three steps: waiting for operands, executing, and waiting to write back.

Two tables hold the state. There is one status entry per unit, and one entry per architectural register naming the unit that will write it. From these the block grants each unit permission to read its operands once no read-after-write hazard remains. It grants permission to write its result once no older instruction still needs the old register value. There is no forwarding and no renaming, so every hazard is resolved by waiting. Execution latency is external: a unit reports completion with a done pulse. Instructions in different units may execute and finish in any order.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset every unit is free, every register-status entry holds the none code (NUM_FU), no read or write grant is raised, and `disp_ready` is high for any class and destination.
- R2: The op class value c selects unit c. `disp_ready` is low while unit c is busy, and a held instruction waits without being consumed (in-order stall).
- R3: `disp_ready` is low while any active unit is recorded as the future writer of the dispatched destination register.
- R4: While an earlier instruction waits for operands in its unit, a later instruction that targets a different free unit and has no write-after-write conflict is accepted in the same cycle it is presented.
- R5: `rd_grant[u]` is raised only while unit u holds an instruction that has not yet read its operands and neither source has a pending writer. It stays high for exactly one cycle, after which the unit is executing.
- R6: A consumer's read grant comes no earlier than the cycle after its producer's write grant. A source whose producer is granted write in the dispatch cycle counts as available.
- R7: `wr_grant[u]` is withheld while another active unit has not yet read an operand register equal to unit u's destination.
- R8: At most one write grant is raised per cycle, and it goes to the lowest-indexed unit that has finished and is free of write-after-read hazards.
- R9: `exec_done[u]` has an effect only while unit u is executing. A done pulse at any other time is ignored.
- R10: A unit that receives a write grant is free in the next cycle: its register-status entry is cleared and waiting readers of that register are woken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | An instruction is presented for dispatch |
| disp_class | input | FU_W | Op class, equal to the target unit index |
| disp_dst | input | REG_W | Destination register |
| disp_src1 | input | REG_W | First source register |
| disp_src2 | input | REG_W | Second source register |
| disp_ready | output | 1 | The presented instruction is accepted this cycle if valid |
| exec_done | input | NUM_FU | Per-unit execution-complete pulse |
| rd_grant | output | NUM_FU | Per-unit permission to read operands |
| wr_grant | output | NUM_FU | Per-unit permission to write its result |

## Verification
The bench targets the cycle in which a write grant and a dispatch reading that same register coincide. A design without the same-cycle availability rule would leave the consumer waiting forever on a writer that has already gone. Completed units that race for the single write slot are checked for lowest-index order; a wrong priority shows up as the wrong `wr_grant` bit. The bench also covers a finished writer whose destination is still an unread source of an older waiting instruction. Granting that write early would destroy the old value, and a design that got it wrong would raise `wr_grant` cycles too soon. Stray done pulses to idle or waiting units are applied throughout; a design that honoured them would produce write grants before any read grant.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_WAIT_OPS = 2'd1,
    PH_EXEC     = 2'd2,
    PH_DONE     = 2'd3
  } phase_e;

  function automatic logic operand_clear(input logic ready_flag);
    return ready_flag;
  endfunction
endpackage

// File: rtl/sb_unit_entry.sv
module sb_unit_entry
  import sb_pkg::*;
#(
  parameter int REG_W = 3,
  parameter int Q_W   = 3,
  parameter int NONE  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [REG_W-1:0] a_dst,
  input  logic [REG_W-1:0] a_src1,
  input  logic [REG_W-1:0] a_src2,
  input  logic [Q_W-1:0]   a_q1,
  input  logic [Q_W-1:0]   a_q2,
  input  logic             rd_go,
  input  logic             done_in,
  input  logic             wr_go,
  input  logic             wake_valid,
  input  logic [Q_W-1:0]   wake_id,
  output phase_e           phase_o,
  output logic [REG_W-1:0] fi_o,
  output logic [REG_W-1:0] fj_o,
  output logic [REG_W-1:0] fk_o,
  output logic             rj_o,
  output logic             rk_o
);
  localparam logic [Q_W-1:0] QNONE = Q_W'(NONE);

  phase_e           phase;
  logic [REG_W-1:0] fi, fj, fk;
  logic [Q_W-1:0]   qj, qk;
  logic             rj, rk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      fi <= '0; fj <= '0; fk <= '0;
      qj <= QNONE; qk <= QNONE;
      rj <= 1'b0; rk <= 1'b0;
    end else if (alloc) begin
      phase <= PH_WAIT_OPS;
      fi <= a_dst; fj <= a_src1; fk <= a_src2;
      qj <= a_q1;  qk <= a_q2;
      rj <= (a_q1 == QNONE);
      rk <= (a_q2 == QNONE);
    end else begin
      unique case (phase)
        PH_WAIT_OPS: begin
          if (rd_go) begin
            phase <= PH_EXEC;
            rj <= 1'b0;
            rk <= 1'b0;
          end else begin
            if (wake_valid && qj == wake_id) begin
              qj <= QNONE;
              rj <= 1'b1;
            end
            if (wake_valid && qk == wake_id) begin
              qk <= QNONE;
              rk <= 1'b1;
            end
          end
        end
        PH_EXEC: if (done_in) phase <= PH_DONE;
        PH_DONE: if (wr_go) phase <= PH_IDLE;
        default: ;
      endcase
    end
  end

  assign phase_o = phase;
  assign fi_o = fi;
  assign fj_o = fj;
  assign fk_o = fk;
  assign rj_o = rj;
  assign rk_o = rk;
endmodule

// File: rtl/sb_regstat.sv
module sb_regstat #(
  parameter int NUM_REG = 8,
  parameter int REG_W   = 3,
  parameter int Q_W     = 3,
  parameter int NONE    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_idx,
  input  logic [Q_W-1:0]   set_val,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_idx,
  input  logic [REG_W-1:0] look_a,
  input  logic [REG_W-1:0] look_b,
  input  logic [REG_W-1:0] look_c,
  output logic [Q_W-1:0]   val_a,
  output logic [Q_W-1:0]   val_b,
  output logic [Q_W-1:0]   val_c
);
  logic [Q_W-1:0] owner [NUM_REG];

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) owner[r] <= Q_W'(NONE);
      else if (set_en && set_idx == REG_W'(r)) owner[r] <= set_val;
      else if (clr_en && clr_idx == REG_W'(r)) owner[r] <= Q_W'(NONE);
    end
  end

  assign val_a = owner[look_a];
  assign val_b = owner[look_b];
  assign val_c = owner[look_c];
endmodule

// File: rtl/sb_prio_pick.sv
module sb_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  function automatic logic [N-1:0] lowest_set(input logic [N-1:0] v);
    logic [N-1:0] r;
    logic         found;
    r = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (v[i] && !found) begin
        r[i]  = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  assign gnt = lowest_set(req);
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int FU_W   = $clog2(NUM_FU),
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [FU_W-1:0]   disp_class,
  input  logic [REG_W-1:0]  disp_dst,
  input  logic [REG_W-1:0]  disp_src1,
  input  logic [REG_W-1:0]  disp_src2,
  output logic              disp_ready,
  input  logic [NUM_FU-1:0] exec_done,
  output logic [NUM_FU-1:0] rd_grant,
  output logic [NUM_FU-1:0] wr_grant
);
  localparam int Q_W  = $clog2(NUM_FU + 1);
  localparam int NONE = NUM_FU;
  localparam logic [Q_W-1:0] QNONE = Q_W'(NONE);

  phase_e           u_phase [NUM_FU];
  logic [REG_W-1:0] u_fi [NUM_FU];
  logic [REG_W-1:0] u_fj [NUM_FU];
  logic [REG_W-1:0] u_fk [NUM_FU];
  logic [NUM_FU-1:0] u_rj, u_rk;

  logic [NUM_FU-1:0] unit_busy, war_block, wr_ready;
  logic [Q_W-1:0]    q_src1, q_src2, q_dst, q1_eff, q2_eff;
  logic              disp_fire, wr_any;
  logic [Q_W-1:0]    wr_id;
  logic [REG_W-1:0]  wr_reg;

  // Per-unit status entries
  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    sb_unit_entry #(.REG_W(REG_W), .Q_W(Q_W), .NONE(NONE)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .alloc(disp_fire && disp_class == FU_W'(u)),
      .a_dst(disp_dst), .a_src1(disp_src1), .a_src2(disp_src2),
      .a_q1(q1_eff), .a_q2(q2_eff),
      .rd_go(rd_grant[u]), .done_in(exec_done[u]), .wr_go(wr_grant[u]),
      .wake_valid(wr_any), .wake_id(wr_id),
      .phase_o(u_phase[u]), .fi_o(u_fi[u]), .fj_o(u_fj[u]), .fk_o(u_fk[u]),
      .rj_o(u_rj[u]), .rk_o(u_rk[u])
    );
    assign unit_busy[u] = (u_phase[u] != PH_IDLE);
    assign rd_grant[u]  = (u_phase[u] == PH_WAIT_OPS) &&
                          operand_clear(u_rj[u]) && operand_clear(u_rk[u]);
    assign wr_ready[u]  = (u_phase[u] == PH_DONE) && !war_block[u];
  end

  // Write-after-read: another unit still needs the old value of our destination
  always_comb begin
    war_block = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      for (int v = 0; v < NUM_FU; v++) begin
        if (v != u && unit_busy[v] &&
            ((u_fj[v] == u_fi[u] && u_rj[v]) || (u_fk[v] == u_fi[u] && u_rk[v])))
          war_block[u] = 1'b1;
      end
    end
  end

  sb_prio_pick #(.N(NUM_FU)) u_pick (.req(wr_ready), .gnt(wr_grant));

  always_comb begin
    wr_id  = QNONE;
    wr_reg = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (wr_grant[u]) begin
        wr_id  = Q_W'(u);
        wr_reg = u_fi[u];
      end
    end
  end
  assign wr_any = |wr_grant;

  sb_regstat #(.NUM_REG(NUM_REG), .REG_W(REG_W), .Q_W(Q_W), .NONE(NONE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .set_en(disp_fire), .set_idx(disp_dst), .set_val(Q_W'(disp_class)),
    .clr_en(wr_any), .clr_idx(wr_reg),
    .look_a(disp_src1), .look_b(disp_src2), .look_c(disp_dst),
    .val_a(q_src1), .val_b(q_src2), .val_c(q_dst)
  );

  // A producer granted write this cycle leaves the register file current
  assign q1_eff = (wr_any && q_src1 == wr_id) ? QNONE : q_src1;
  assign q2_eff = (wr_any && q_src2 == wr_id) ? QNONE : q_src2;

  assign disp_ready = !unit_busy[disp_class] && (q_dst == QNONE);
  assign disp_fire  = disp_valid && disp_ready;
endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
  parameter int NUM_FU = 4,
  parameter int FU_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [FU_W-1:0]   disp_class,
  input logic [NUM_FU-1:0] rd_grant,
  input logic [NUM_FU-1:0] wr_grant,
  input logic [NUM_FU-1:0] wr_ready,
  input logic [NUM_FU-1:0] unit_busy,
  input logic [NUM_FU-1:0] war_block
);
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_grant)); // R8

  AST_WR_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_grant) |-> (((wr_grant - 1'b1) & wr_ready) == '0)); // R8

  AST_WR_NO_WAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant & war_block) == '0); // R7

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_grant) |=> ((rd_grant & $past(rd_grant)) == '0)); // R5

  AST_DISP_TAKES_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> unit_busy[$past(disp_class)]); // R2

  AST_WR_FREES_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_grant) |=> ((unit_busy & $past(wr_grant)) == '0)); // R10
endmodule

bind sb_scoreboard sb_scoreboard_chk #(.NUM_FU(NUM_FU), .FU_W(FU_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_class(disp_class), .rd_grant(rd_grant), .wr_grant(wr_grant),
  .wr_ready(wr_ready), .unit_busy(unit_busy), .war_block(war_block)
);

// File: tb/tb_sb_scoreboard.sv
module tb_sb_scoreboard;
  localparam int NF = 4;
  localparam int NR = 8;
  localparam int RUN_CYCLES = 4000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          disp_valid = 1'b0;
  logic [1:0]    disp_class = '0;
  logic [2:0]    disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
  logic          disp_ready;
  logic [NF-1:0] exec_done = '0;
  logic [NF-1:0] rd_grant, wr_grant;

  always #2 clk = ~clk; // 250 MHz

  sb_scoreboard #(.NUM_FU(NF), .NUM_REG(NR)) dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_class(disp_class),
    .disp_dst(disp_dst), .disp_src1(disp_src1), .disp_src2(disp_src2),
    .disp_ready(disp_ready), .exec_done(exec_done),
    .rd_grant(rd_grant), .wr_grant(wr_grant)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Reference model state: phase 0 idle, 1 waiting, 2 executing, 3 finished
  int mph[NF], mfi[NF], mfj[NF], mfk[NF], mqj[NF], mqk[NF], mcnt[NF];
  bit mrj[NF], mrk[NF];
  int mreg[NR];

  // Directed opening: RAW chain, WAW stall, structural stall, WAR window
  int dir_c[8] = '{0, 1, 2, 3, 1, 2, 0, 3};
  int dir_d[8] = '{1, 4, 1, 2, 5, 3, 6, 7};
  int dir_a[8] = '{2, 1, 5, 1, 6, 2, 1, 2};
  int dir_b[8] = '{3, 1, 6, 4, 6, 0, 1, 3};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit war_held(int u);
    for (int v = 0; v < NF; v++)
      if (v != u && mph[v] != 0 &&
          ((mfj[v] == mfi[u] && mrj[v]) || (mfk[v] == mfi[u] && mrk[v])))
        return 1;
    return 0;
  endfunction

  initial begin
    int  idx;
    int  c, d, s1, s2;
    bit  have;
    for (int u = 0; u < NF; u++) begin
      mph[u] = 0; mqj[u] = -1; mqk[u] = -1; mrj[u] = 0; mrk[u] = 0; mcnt[u] = 0;
      mfi[u] = 0; mfj[u] = 0; mfk[u] = 0;
    end
    for (int r = 0; r < NR; r++) mreg[r] = -1;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 disp_ready after reset", 32'(disp_ready), 32'd1);
    check("R1 rd_grant after reset", 32'(rd_grant), 32'd0);
    check("R1 wr_grant after reset", 32'(wr_grant), 32'd0);

    idx = 0; have = 0; c = 0; d = 0; s1 = 0; s2 = 0;
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      logic [NF-1:0] erd, ewr, dn;
      bit eready, fire, vld;
      int w;
      @(negedge clk);
      if (!have) begin
        if (idx < 8) begin
          c = dir_c[idx]; d = dir_d[idx]; s1 = dir_a[idx]; s2 = dir_b[idx];
        end else begin
          c = int'($urandom % NF); d = int'($urandom % NR);
          s1 = int'($urandom % NR); s2 = int'($urandom % NR);
        end
        have = 1;
      end
      vld = (idx < 8) || ($urandom % 5 != 0);
      // done pulses: real ones when latency expires, stray ones elsewhere (R9)
      for (int u = 0; u < NF; u++) begin
        if (mph[u] == 2) dn[u] = (mcnt[u] == 0);
        else dn[u] = ($urandom % 4 == 0);
      end
      disp_valid = vld; disp_class = 2'(c); disp_dst = 3'(d);
      disp_src1 = 3'(s1); disp_src2 = 3'(s2); exec_done = dn;
      #1;
      // expected outputs
      eready = (mph[c] == 0) && (mreg[d] == -1);
      for (int u = 0; u < NF; u++) erd[u] = (mph[u] == 1) && mrj[u] && mrk[u];
      ewr = '0; w = -1;
      for (int u = 0; u < NF; u++)
        if (w < 0 && mph[u] == 3 && !war_held(u)) begin
          w = u; ewr[u] = 1'b1;
        end
      check("R2 R3 R4 R10 disp_ready", 32'(disp_ready), 32'(eready));
      check("R5 R6 rd_grant", 32'(rd_grant), 32'(erd));
      check("R7 R8 R9 wr_grant", 32'(wr_grant), 32'(ewr));
      fire = vld && eready;
      @(posedge clk);
      // model update
      for (int u = 0; u < NF; u++) begin
        if (erd[u]) begin
          mph[u] = 2; mrj[u] = 0; mrk[u] = 0; mcnt[u] = int'($urandom % 4);
        end else if (mph[u] == 2) begin
          if (dn[u]) mph[u] = 3;
          else if (mcnt[u] > 0) mcnt[u]--;
        end
      end
      if (w >= 0) begin
        mph[w] = 0;
        mreg[mfi[w]] = -1;
        for (int u = 0; u < NF; u++)
          if (mph[u] == 1) begin
            if (mqj[u] == w) begin mqj[u] = -1; mrj[u] = 1; end
            if (mqk[u] == w) begin mqk[u] = -1; mrk[u] = 1; end
          end
      end
      if (fire) begin
        mph[c] = 1; mfi[c] = d; mfj[c] = s1; mfk[c] = s2;
        mqj[c] = mreg[s1]; mqk[c] = mreg[s2];
        mrj[c] = (mqj[c] == -1); mrk[c] = (mqk[c] == -1);
        mreg[d] = c;
        have = 0; idx++;
      end
    end
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule